// File: doc/BRIEF.md
# Timer Channel Fast Trigger Compare

One output channel of a general-purpose timer. It compares a counter value, supplied from outside, against a compare value. In its output mode it drives a pulse-width waveform: the channel output is active while the count is at or above the compare value. An external trigger can also push the output to its active level before the comparison would. Each rising edge on the trigger counts as a compare match. The output then stays active until the counter wraps to zero.

The trigger may be asynchronous, so it passes through a two-stage synchronizer and an edge detector. The fast-enable input selects how long the trigger takes to reach the output. With fast enable set, the path is short. With it clear, two padding stages lengthen it. Both delays are fixed. A two-bit mode field is loaded through a write strobe. It can be changed only while the channel is disabled. Any mode other than output keeps the channel output inactive.

Top module: `timer_fast_cmp`

## Requirements
- R1: With `chan_en` high and mode 00, `ch_out` after a rising clock edge is 1 when the unsigned `cnt_in` sampled at that edge is greater than or equal to `cmp_in`, and 0 otherwise. This holds when no trigger match is pending.
- R2: With `fast_en` high, a rising edge of `trig_in` is first sampled high at clock edge E0. `ch_out` is then 1 after edge E0+2, which is the third sampling edge, whatever the comparison gives. It is not driven high by the trigger any earlier.
- R3: With `fast_en` low, the same trigger edge makes `ch_out` 1 after edge E0+4, which is the fifth sampling edge, and not earlier.
- R4: Once a trigger match has taken effect, `ch_out` stays 1 while the sampled `cnt_in` is nonzero. At the first edge that samples `cnt_in` equal to 0, the output goes back to following R1.
- R5: Mode values 01, 10 and 11 are input modes. In any of them `ch_out` is 0 one cycle later, whatever the count, compare value and trigger are.
- R6: A write (`mode_we` high) loads `mode_wdata` into the mode field only at an edge where `chan_en` is low. A write while `chan_en` is high is ignored, so the channel keeps its current behaviour.
- R7: With `chan_en` low, `ch_out` is 0 one cycle later, and any pending trigger match is dropped.
- R8: Reset (`rst_n` low, asynchronous) forces `ch_out` to 0, sets the mode field to 00 (output), and clears the synchronizer and edge-detector stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | CW | Current counter value |
| cmp_in | input | CW | Compare value |
| trig_in | input | 1 | Trigger, may be asynchronous; rising edge is active |
| fast_en | input | 1 | 1 selects the short trigger path, 0 selects the long one |
| chan_en | input | 1 | Channel enable |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | New mode value: 00 output, 01/10/11 input |
| ch_out | output | 1 | Channel output, active high |

## Verification
The bench counts edges from the first sample of each trigger rise and checks that the output rises on exactly the third or fifth edge. A pipeline that is one stage too short or too long would rise a cycle early or late and be flagged on that exact cycle. Trigger matches are fired while the count is below the compare value. The bench then keeps the count nonzero and lets it wrap. A hold that never clears would leave the output stuck high after the wrap. A hold that clears too early would drop the output before the wrap. Mode writes are tried both with the channel enabled and with it disabled. A design that accepts writes while enabled would go silent on a compare that should drive the output. A design that ignores the input modes would keep producing the waveform.

// File: rtl/timer_fast_cmp.sv
module timer_fast_cmp #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_in,
  input  logic [CW-1:0] cmp_in,
  input  logic          trig_in,
  input  logic          fast_en,
  input  logic          chan_en,
  input  logic          mode_we,
  input  logic [1:0]    mode_wdata,
  output logic          ch_out
);

  localparam logic [1:0]    MODE_OUT = 2'b00;
  localparam logic [CW-1:0] CNT_ZERO = '0;

  logic [1:0] mode_q;
  logic [2:0] sync_q;
  logic [1:0] pad_q;
  logic       hold_q;
  logic       ch_q;

  logic trig_edge, match_pulse, active, cmp_hit, ch_next, hold_next;

  assign trig_edge   = sync_q[1] & ~sync_q[2];
  assign match_pulse = fast_en ? trig_edge : pad_q[1];
  assign active      = chan_en && (mode_q == MODE_OUT);
  assign cmp_hit     = cnt_in >= cmp_in;
  assign hold_next   = active && (match_pulse || (hold_q && cnt_in != CNT_ZERO));
  assign ch_next     = active && (cmp_hit || hold_next);
  assign ch_out      = ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      pad_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], trig_in};
      pad_q  <= {pad_q[0], trig_edge};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= MODE_OUT;
    else if (mode_we && !chan_en)
      mode_q <= mode_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      ch_q   <= 1'b0;
    end else begin
      hold_q <= hold_next;
      ch_q   <= ch_next;
    end
  end

  a_r1_compare_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && mode_q == MODE_OUT && cnt_in >= cmp_in) |=> ch_out);

  a_r2_fast_match: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && trig_edge && chan_en && mode_q == MODE_OUT) |=> ch_out);

  a_r3_slow_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_en && pad_q[1] && chan_en && mode_q == MODE_OUT) |=> ch_out);

  a_r4_hold_until_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && cnt_in != CNT_ZERO && chan_en && mode_q == MODE_OUT) |=> ch_out);

  a_r5_input_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_OUT) |=> !ch_out);

  a_r6_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(mode_q));

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!ch_out && !hold_q));

endmodule

// File: tb/test_timer_fast_cmp.sv
module test_timer_fast_cmp;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_in = '0;
  logic [CW-1:0] cmp_in = '0;
  logic          trig_in = 1'b0;
  logic          fast_en = 1'b0;
  logic          chan_en = 1'b0;
  logic          mode_we = 1'b0;
  logic [1:0]    mode_wdata = 2'b00;
  logic          ch_out;

  timer_fast_cmp #(.CW(CW)) i_timer_fast_cmp (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .cmp_in(cmp_in),
    .trig_in(trig_in), .fast_en(fast_en), .chan_en(chan_en),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .ch_out(ch_out)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit th[0:8191];
  int n = 0;
  logic [1:0] m_mode = 2'b00;
  bit m_hold = 1'b0;

  function automatic bit rise(int k);
    if (k < 1) return 1'b0;
    return th[k] && !th[k-1];
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: ch_out=%b expected=%b", tag, n, act, exp);
    end
  endtask

  task automatic drive(int c, int cp, bit tg, bit fe, bit en, bit we, logic [1:0] md, string tag);
    bit pulse, act, e;
    @(negedge clk);
    cnt_in = c[CW-1:0]; cmp_in = cp[CW-1:0]; trig_in = tg; fast_en = fe;
    chan_en = en; mode_we = we; mode_wdata = md;
    th[n] = tg;
    pulse = fe ? rise(n - 2) : rise(n - 4);
    act = en && (m_mode == 2'b00);
    e = act && ((c >= cp) || pulse || (m_hold && c != 0));
    m_hold = act && (pulse || (m_hold && c != 0));
    if (we && !en) m_mode = md;
    q.push_back('{exp: e, tag: tag});
    n++;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(ch_out, it.exp, it.tag);
      end
    end
  end

  task automatic fire(bit fe, int cp, string tag);
    for (int k = 0; k < 30; k++) begin
      int c;
      c = 40 + k;
      if (k >= 24) c = (k == 24) ? 0 : k;
      drive(c, cp, (k >= 3 && k < 12), fe, 1'b1, 1'b0, 2'b00, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ch_out, 1'b0, "R8 reset output");
    rst_n = 1'b1;
    drive(0, 5, 0, 0, 0, 0, 2'b00, "R8 idle");
    drive(9, 5, 0, 0, 1, 0, 2'b00, "R8 mode after reset is output");
    for (int k = 0; k < 20; k++) drive(k, 10, 0, 0, 1, 0, 2'b00, "R1 ramp");
    for (int k = 0; k < 12; k++) drive(255 - k * 20, 128, 0, 1, 1, 0, 2'b00, "R1 falling pattern");
    drive(255, 255, 0, 0, 1, 0, 2'b00, "R1 equal at max");
    drive(0, 0, 0, 0, 1, 0, 2'b00, "R1 equal at zero");
    for (int k = 0; k < 4; k++) drive(200, 10, 0, 0, 0, 0, 2'b00, "R7 disabled");
    fire(1'b1, 200, "R2 fast trigger");
    fire(1'b0, 200, "R3 slow trigger");
    fire(1'b1, 200, "R4 hold until wrap");
    for (int k = 0; k < 8; k++) drive(50 + k, 200, (k >= 1 && k < 6), 0, (k < 4), 0, 2'b00, "R7 drop pending match");
    for (int k = 0; k < 4; k++) drive(50, 200, 0, 0, 1, 0, 2'b00, "R7 match dropped");
    for (int md = 1; md < 4; md++) begin
      drive(0, 10, 0, 0, 0, 1, md[1:0], "R6 write while disabled");
      for (int k = 0; k < 10; k++) drive(100 + k, 10, (k >= 2 && k < 6), 1, 1, 0, 2'b00, "R5 input mode quiet");
    end
    drive(0, 10, 0, 0, 0, 1, 2'b00, "R6 write output mode");
    drive(100, 10, 0, 0, 1, 1, 2'b01, "R6 write while enabled");
    for (int k = 0; k < 6; k++) drive(100, 10, 0, 0, 1, (k < 3), 2'b10, "R6 write ignored");
    drive(5, 10, 0, 0, 1, 0, 2'b00, "R1 below compare");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: expected=finished actual=hung");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule